// File: doc/BRIEF.md
# Data Access Address Translator

This block turns one data access into a physical address and a verdict. Each request carries a virtual address, an access size in bytes, a read/write flag, three request qualifiers (physical pass-through, alternate-mode permission, page-table-entry load) and the current privilege mode. The block also takes the result of a lookup that a separate TLB has already done for the same address: a hit flag, a physical page number, per-mode read and write enable masks and the fault-on-read and fault-on-write bits. From these it picks one of three address sources: a direct pass-through, a kernel-only superpage window, or the TLB entry.

The chosen address then goes through a fixed sequence of checks. These cover alignment, virtual address form, the superpage mode rule, TLB presence, per-mode permission, the fault-on bits and the implemented physical range. The first check that fails sets the one fault bit of the response. If no check fails, the response carries the physical address. When the top implemented address bit marks the access as uncached, the response also raises an uncacheable flag and clears the address bits that hold I/O space selectors. The response is registered and appears on the cycle after the request.

Top module: `dxlate_core`

## Requirements
- R1: A response is registered: `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high. In any cycle after one without a request, `rsp_valid`, `rsp_fault`, `rsp_paddr` and `rsp_uncached` are all zero, and reset clears them too.
- R2: If `req_vaddr & (req_size - 1)` is nonzero, the fault is alignment (`rsp_fault` = 6'b000001). This check ranks above every other check, including on physical requests.
- R3: With `req_phys` set, the physical address equals the virtual address. No validity, superpage, TLB or permission check applies.
- R4: A non-physical request whose virtual bits 63:42 are not all equal raises a page fault (`rsp_fault` = 6'b000100).
- R5: A non-physical request with virtual bits 47:41 equal to 7'h7E uses the superpage window and ignores the TLB inputs. If `cur_mode` is not kernel (0), it raises an access violation (`rsp_fault` = 6'b000010).
- R6: A superpage address is the virtual address masked to 44 bits. If bit 40 of that value is set, bits 43:40 are forced to one. Otherwise the value is masked to 40 bits.
- R7: A translated request with `tlb_hit` low raises a page-table-load miss (6'b010000) when `req_vpte` is set and a native miss (6'b001000) otherwise.
- R8: On a TLB hit the physical address is `tlb_ppn` shifted left by 13, with virtual bits 12:0 as the offset.
- R9: The permission mode is `alt_mode` when `req_alt` is set and `cur_mode` otherwise. Modes are encoded kernel=0, executive=1, supervisor=2, user=3. Bit [mode] of `tlb_wr_en` (writes) or `tlb_rd_en` (reads) must be set; if it is clear, the fault is an access violation.
- R10: If permission is granted but `tlb_fault_wr` (writes) or `tlb_fault_rd` (reads) is set, the fault is a page fault. The bit for the other direction has no effect.
- R11: A fault-free result with any physical address bit at or above bit 44 set raises a machine check (6'b100000).
- R12: A fault-free result with physical bit 43 set raises `rsp_uncached` and clears physical bits 42:35.
- R13: `rsp_fault` has at most one bit set. On a fault, `rsp_paddr` and `rsp_uncached` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_vaddr | input | 64 | Virtual address |
| req_size | input | 4 | Access size in bytes (1, 2, 4, 8) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_phys | input | 1 | Physical pass-through request |
| req_alt | input | 1 | Check permission in `alt_mode` |
| req_vpte | input | 1 | Request is a page-table-entry load |
| cur_mode | input | 2 | Current privilege mode |
| alt_mode | input | 2 | Alternate privilege mode |
| tlb_hit | input | 1 | External TLB lookup hit |
| tlb_ppn | input | 32 | Physical page number of the hit entry |
| tlb_rd_en | input | 4 | Per-mode read enable mask |
| tlb_wr_en | input | 4 | Per-mode write enable mask |
| tlb_fault_rd | input | 1 | Entry fault-on-read bit |
| tlb_fault_wr | input | 1 | Entry fault-on-write bit |
| rsp_valid | output | 1 | Response present |
| rsp_paddr | output | 44 | Physical address, zero on fault |
| rsp_uncached | output | 1 | Access is uncacheable |
| rsp_fault | output | 6 | One-hot fault: [0] align, [1] access violation, [2] page fault, [3] native miss, [4] PTE-load miss, [5] machine check |

## Verification
A vector table drives each address source in turn: pass-through, the superpage window with bit 40 clear and set, and TLB hits with small, oversize and uncached page numbers. These patterns separate the three address formations and show whether the bit-40 extension and the uncached clearing each act only where they should. Further vectors pair a failing check with a later one, such as misalignment on a physical request or a cleared enable bit next to a set fault-on bit, so a wrong priority order shows up as the wrong fault bit. Alternate-mode and opposite-direction fault-on vectors confirm that only the selected mode bit and the matching direction bit matter. Directed steps then cover reset, idle cycles and back-to-back requests.

// File: rtl/dxlate_pkg.sv
package dxlate_pkg;
    localparam int VA_W_DEF     = 64;
    localparam int PA_W_DEF     = 44;
    localparam int PPN_W_DEF    = 32;
    localparam int PG_SHIFT_DEF = 13;
    localparam int SZ_W_DEF     = 4;
    localparam int NMODE_DEF    = 4;

    localparam int F_ALIGN = 0;
    localparam int F_ACV   = 1;
    localparam int F_PAGE  = 2;
    localparam int F_NMISS = 3;
    localparam int F_PMISS = 4;
    localparam int F_MCHK  = 5;
    localparam int NFAULT  = 6;

    typedef logic [NFAULT-1:0] fault_t;

    typedef enum logic [1:0] {
        SRC_PHYS = 2'd0,
        SRC_SPG  = 2'd1,
        SRC_TLB  = 2'd2
    } pa_src_e;
endpackage

// File: rtl/dxlate_align.sv
module dxlate_align #(
    parameter int VA_W = 64,
    parameter int SZ_W = 4
) (
    input  logic [VA_W-1:0] vaddr,
    input  logic [SZ_W-1:0] size,
    output logic            misaligned
);
    logic [SZ_W-1:0] low_mask;

    always_comb begin
        low_mask   = size - SZ_W'(1);
        misaligned = |(vaddr[SZ_W-1:0] & low_mask);
    end
endmodule

// File: rtl/dxlate_perm.sv
module dxlate_perm #(
    parameter int NMODE  = 4,
    localparam int MODE_W = $clog2(NMODE)
) (
    input  logic [MODE_W-1:0] mode,
    input  logic              is_write,
    input  logic [NMODE-1:0]  rd_en,
    input  logic [NMODE-1:0]  wr_en,
    input  logic              fault_rd,
    input  logic              fault_wr,
    output logic              acv,
    output logic              pfault
);
    logic [NMODE-1:0] en_mask;
    logic             fo_bit;

    always_comb begin
        en_mask = is_write ? wr_en : rd_en;
        fo_bit  = is_write ? fault_wr : fault_rd;
        acv     = !en_mask[mode];
        pfault  = en_mask[mode] && fo_bit;
    end
endmodule

// File: rtl/dxlate_pa_form.sv
module dxlate_pa_form
    import dxlate_pkg::*;
#(
    parameter int VA_W     = 64,
    parameter int PA_W     = 44,
    parameter int PPN_W    = 32,
    parameter int PG_SHIFT = 13,
    parameter int SP_BIT   = 40,
    parameter int UNC_LO   = 35,
    localparam int UNC_HI  = PA_W - 2,
    localparam int PAD_W   = VA_W - PPN_W - PG_SHIFT
) (
    input  pa_src_e          src,
    input  logic [VA_W-1:0]  vaddr,
    input  logic [PPN_W-1:0] ppn,
    output logic [PA_W-1:0]  paddr,
    output logic             uncached,
    output logic             mcheck
);
    logic [VA_W-1:0] raw_pa;
    logic [VA_W-1:0] spg_pa;

    always_comb begin
        spg_pa = {{(VA_W-PA_W){1'b0}}, vaddr[PA_W-1:0]};
        if (spg_pa[SP_BIT]) begin
            spg_pa[PA_W-1:SP_BIT] = '1;
        end else begin
            spg_pa[VA_W-1:SP_BIT] = '0;
        end
        unique case (src)
            SRC_PHYS: raw_pa = vaddr;
            SRC_SPG:  raw_pa = spg_pa;
            default:  raw_pa = {{PAD_W{1'b0}}, ppn, vaddr[PG_SHIFT-1:0]};
        endcase
        mcheck   = |raw_pa[VA_W-1:PA_W];
        uncached = raw_pa[PA_W-1];
    end

    for (genvar b = 0; b < PA_W; b++) begin : g_pa_bit
        if (b >= UNC_LO && b <= UNC_HI) begin : g_clr
            assign paddr[b] = raw_pa[b] & ~uncached;
        end else begin : g_keep
            assign paddr[b] = raw_pa[b];
        end
    end
endmodule

// File: rtl/dxlate_core.sv
module dxlate_core
    import dxlate_pkg::*;
#(
    parameter int VA_W     = VA_W_DEF,
    parameter int PA_W     = PA_W_DEF,
    parameter int PPN_W    = PPN_W_DEF,
    parameter int PG_SHIFT = PG_SHIFT_DEF,
    parameter int SZ_W     = SZ_W_DEF,
    parameter int NMODE    = NMODE_DEF,
    parameter int VA_SIGN  = 42,
    parameter int SP_HI    = 47,
    parameter int SP_LO    = 41,
    parameter logic [SP_HI-SP_LO:0] SP_TAG = 7'h7E,
    parameter int SP_BIT   = 40,
    parameter int UNC_LO   = 35,
    localparam int MODE_W  = $clog2(NMODE),
    localparam int UNC_HI  = PA_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic [SZ_W-1:0]   req_size,
    input  logic              req_write,
    input  logic              req_phys,
    input  logic              req_alt,
    input  logic              req_vpte,
    input  logic [MODE_W-1:0] cur_mode,
    input  logic [MODE_W-1:0] alt_mode,
    input  logic              tlb_hit,
    input  logic [PPN_W-1:0]  tlb_ppn,
    input  logic [NMODE-1:0]  tlb_rd_en,
    input  logic [NMODE-1:0]  tlb_wr_en,
    input  logic              tlb_fault_rd,
    input  logic              tlb_fault_wr,
    output logic              rsp_valid,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic              rsp_uncached,
    output fault_t            rsp_fault
);
    typedef struct packed {
        logic            valid;
        logic [PA_W-1:0] paddr;
        logic            unc;
        fault_t          fault;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    logic              misalign;
    logic              va_ok;
    logic              spg_sel;
    logic [MODE_W-1:0] mode_eff;
    logic              perm_acv;
    logic              perm_pf;
    pa_src_e           src;
    logic [PA_W-1:0]   pa_fin;
    logic              pa_unc;
    logic              pa_mchk;

    dxlate_align #(.VA_W(VA_W), .SZ_W(SZ_W)) align_i (
        .vaddr      (req_vaddr),
        .size       (req_size),
        .misaligned (misalign)
    );

    dxlate_perm #(.NMODE(NMODE)) perm_i (
        .mode     (mode_eff),
        .is_write (req_write),
        .rd_en    (tlb_rd_en),
        .wr_en    (tlb_wr_en),
        .fault_rd (tlb_fault_rd),
        .fault_wr (tlb_fault_wr),
        .acv      (perm_acv),
        .pfault   (perm_pf)
    );

    dxlate_pa_form #(
        .VA_W(VA_W), .PA_W(PA_W), .PPN_W(PPN_W), .PG_SHIFT(PG_SHIFT),
        .SP_BIT(SP_BIT), .UNC_LO(UNC_LO)
    ) pa_i (
        .src      (src),
        .vaddr    (req_vaddr),
        .ppn      (tlb_ppn),
        .paddr    (pa_fin),
        .uncached (pa_unc),
        .mcheck   (pa_mchk)
    );

    always_comb begin
        va_ok    = (&req_vaddr[VA_W-1:VA_SIGN]) || !(|req_vaddr[VA_W-1:VA_SIGN]);
        spg_sel  = !req_phys && (req_vaddr[SP_HI:SP_LO] == SP_TAG);
        mode_eff = req_alt ? alt_mode : cur_mode;
        if (req_phys)     src = SRC_PHYS;
        else if (spg_sel) src = SRC_SPG;
        else              src = SRC_TLB;

        rsp_d = '0;
        if (req_valid) begin
            rsp_d.valid = 1'b1;
            if (misalign)                           rsp_d.fault[F_ALIGN] = 1'b1;
            else if (!req_phys && !va_ok)           rsp_d.fault[F_PAGE]  = 1'b1;
            else if (spg_sel && cur_mode != '0)     rsp_d.fault[F_ACV]   = 1'b1;
            else if (src == SRC_TLB && !tlb_hit)    rsp_d.fault[req_vpte ? F_PMISS : F_NMISS] = 1'b1;
            else if (src == SRC_TLB && perm_acv)    rsp_d.fault[F_ACV]   = 1'b1;
            else if (src == SRC_TLB && perm_pf)     rsp_d.fault[F_PAGE]  = 1'b1;
            else if (pa_mchk)                       rsp_d.fault[F_MCHK]  = 1'b1;
            else begin
                rsp_d.paddr = pa_fin;
                rsp_d.unc   = pa_unc;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid    = rsp_q.valid;
    assign rsp_paddr    = rsp_q.paddr;
    assign rsp_uncached = rsp_q.unc;
    assign rsp_fault    = rsp_q.fault;

    assert_rsp_follows_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && rsp_fault == '0 && rsp_paddr == '0 && !rsp_uncached));
    assert_align_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && misalign) |=> rsp_fault == fault_t'(1 << F_ALIGN));
    assert_miss_kind_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !misalign && src == SRC_TLB && va_ok && !tlb_hit)
        |=> (rsp_fault[F_NMISS] || rsp_fault[F_PMISS]));
    assert_unc_clears_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_uncached |-> (rsp_paddr[PA_W-1] && rsp_paddr[UNC_HI:UNC_LO] == '0));
    assert_fault_onehot_R13: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rsp_fault));
    assert_fault_zero_pa_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (|rsp_fault) |-> (rsp_paddr == '0 && !rsp_uncached));
endmodule

// File: tb/dxlate_core_tb_top.sv
module dxlate_core_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [63:0] req_vaddr = '0;
    logic [3:0]  req_size = 4'd1;
    logic        req_write = 1'b0;
    logic        req_phys = 1'b0;
    logic        req_alt = 1'b0;
    logic        req_vpte = 1'b0;
    logic [1:0]  cur_mode = '0;
    logic [1:0]  alt_mode = '0;
    logic        tlb_hit = 1'b0;
    logic [31:0] tlb_ppn = '0;
    logic [3:0]  tlb_rd_en = '0;
    logic [3:0]  tlb_wr_en = '0;
    logic        tlb_fault_rd = 1'b0;
    logic        tlb_fault_wr = 1'b0;
    logic        rsp_valid;
    logic [43:0] rsp_paddr;
    logic        rsp_uncached;
    logic [5:0]  rsp_fault;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dxlate_core dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_size(req_size), .req_write(req_write), .req_phys(req_phys),
        .req_alt(req_alt), .req_vpte(req_vpte), .cur_mode(cur_mode),
        .alt_mode(alt_mode), .tlb_hit(tlb_hit), .tlb_ppn(tlb_ppn),
        .tlb_rd_en(tlb_rd_en), .tlb_wr_en(tlb_wr_en),
        .tlb_fault_rd(tlb_fault_rd), .tlb_fault_wr(tlb_fault_wr),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
        .rsp_uncached(rsp_uncached), .rsp_fault(rsp_fault)
    );

    typedef struct packed {
        logic [63:0] va;
        logic [3:0]  sz;
        logic        wr;
        logic        ph;
        logic        alt;
        logic        vpte;
        logic [1:0]  cm;
        logic [1:0]  am;
        logic        hit;
        logic [31:0] ppn;
        logic [3:0]  rde;
        logic [3:0]  wre;
        logic        fonr;
        logic        fonw;
        logic [43:0] epa;
        logic        eunc;
        logic [5:0]  eflt;
    } vec_t;

    localparam int NV = 21;
    // fault codes: 01 align, 02 acv, 04 page, 08 native miss, 10 pte miss, 20 machine check
    localparam vec_t VECS [NV] = '{
        '{64'h1003, 4'd4, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b1, 32'h1, 4'hF, 4'hF, 1'b0, 1'b0, 44'h0, 1'b0, 6'h01},
        '{64'h1001, 4'd2, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 32'h0, 4'h0, 4'h0, 1'b0, 1'b0, 44'h0, 1'b0, 6'h01},
        '{64'h0000_0123_4567_89A8, 4'd8, 1'b0, 1'b1, 1'b0, 1'b0, 2'd3, 2'd0, 1'b0, 32'h0, 4'h0, 4'h0, 1'b0, 1'b0, 44'h123_4567_89A8, 1'b0, 6'h00},
        '{64'h0000_1000_0000_0000, 4'd1, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 32'h0, 4'h0, 4'h0, 1'b0, 1'b0, 44'h0, 1'b0, 6'h20},
        '{64'h0000_0F80_0000_1000, 4'd8, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 32'h0, 4'h0, 4'h0, 1'b0, 1'b0, 44'h800_0000_1000, 1'b1, 6'h00},
        '{64'h0000_8000_0000_0000, 4'd8, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b1, 32'h1, 4'hF, 4'hF, 1'b0, 1'b0, 44'h0, 1'b0, 6'h04},
        '{64'hFFFF_FC00_0000_0000, 4'd8, 1'b0, 1'b0, 1'b0, 1'b0, 2'd3, 2'd0, 1'b1, 32'h1, 4'hF, 4'hF, 1'b0, 1'b0, 44'h0, 1'b0, 6'h02},
        '{64'hFFFF_FC00_0000_2000, 4'd8, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 32'h0, 4'h0, 4'h0, 1'b0, 1'b0, 44'h000_0000_2000, 1'b0, 6'h00},
        '{64'hFFFF_FD00_0000_4000, 4'd8, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 32'h0, 4'h0, 4'h0, 1'b0, 1'b0, 44'h800_0000_4000, 1'b1, 6'h00},
        '{64'h6000, 4'd8, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 32'h5, 4'hF, 4'hF, 1'b0, 1'b0, 44'h0, 1'b0, 6'h08},
        '{64'h6000, 4'd8, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 2'd0, 1'b0, 32'h5, 4'hF, 4'hF, 1'b0, 1'b0, 44'h0, 1'b0, 6'h10},
        '{64'hA5A8, 4'd8, 1'b0, 1'b0, 1'b0, 1'b0, 2'd3, 2'd0, 1'b1, 32'h12345, 4'hF, 4'h0, 1'b0, 1'b0, 44'h000_2468_A5A8, 1'b0, 6'h00},
        '{64'h2008, 4'd8, 1'b1, 1'b0, 1'b0, 1'b0, 2'd3, 2'd1, 1'b1, 32'h1, 4'hF, 4'h7, 1'b0, 1'b0, 44'h0, 1'b0, 6'h02},
        '{64'h2008, 4'd8, 1'b1, 1'b0, 1'b1, 1'b0, 2'd3, 2'd1, 1'b1, 32'h1, 4'hF, 4'h7, 1'b0, 1'b0, 44'h2008, 1'b0, 6'h00},
        '{64'h40, 4'd4, 1'b0, 1'b0, 1'b0, 1'b0, 2'd2, 2'd0, 1'b1, 32'h3, 4'hF, 4'hF, 1'b1, 1'b0, 44'h0, 1'b0, 6'h04},
        '{64'h40, 4'd4, 1'b1, 1'b0, 1'b0, 1'b0, 2'd2, 2'd0, 1'b1, 32'h3, 4'hF, 4'hF, 1'b1, 1'b1, 44'h0, 1'b0, 6'h04},
        '{64'h40, 4'd4, 1'b0, 1'b0, 1'b0, 1'b0, 2'd2, 2'd0, 1'b1, 32'h3, 4'hF, 4'hF, 1'b0, 1'b1, 44'h6040, 1'b0, 6'h00},
        '{64'h0, 4'd8, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b1, 32'h8000_0000, 4'hF, 4'hF, 1'b0, 1'b0, 44'h0, 1'b0, 6'h20},
        '{64'h10, 4'd8, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b1, 32'h7FC0_0001, 4'hF, 4'hF, 1'b0, 1'b0, 44'h800_0000_2010, 1'b1, 6'h00},
        '{64'h40, 4'd4, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b1, 32'h3, 4'hE, 4'hF, 1'b1, 1'b0, 44'h0, 1'b0, 6'h02},
        '{64'h7, 4'd1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b1, 32'h2, 4'hF, 4'hF, 1'b0, 1'b0, 44'h4007, 1'b0, 6'h00}
    };

    function automatic string vtag(int i);
        case (i)
            0, 1, 20: return "R2";
            2:        return "R3";
            3, 17:    return "R11";
            4, 18:    return "R12";
            5:        return "R4";
            6:        return "R5";
            7, 8:     return "R6";
            9, 10:    return "R7";
            11:       return "R8";
            12, 13, 19: return "R9";
            default:  return "R10";
        endcase
    endfunction

    task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic drive(vec_t v);
        req_vaddr = v.va; req_size = v.sz; req_write = v.wr; req_phys = v.ph;
        req_alt = v.alt; req_vpte = v.vpte; cur_mode = v.cm; alt_mode = v.am;
        tlb_hit = v.hit; tlb_ppn = v.ppn; tlb_rd_en = v.rde; tlb_wr_en = v.wre;
        tlb_fault_rd = v.fonr; tlb_fault_wr = v.fonw;
    endtask

    task automatic chk_vec(vec_t v, string tag);
        chk(tag, "valid", 64'(rsp_valid), 64'h1);
        chk(tag, "fault", 64'(rsp_fault), 64'(v.eflt));
        chk(tag, "paddr", 64'(rsp_paddr), 64'(v.epa));
        chk(tag, "uncached", 64'(rsp_uncached), 64'(v.eunc));
        if (v.eflt != 6'h0) chk("R13", "fault clears paddr", 64'(rsp_paddr), 64'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "reset valid", 64'(rsp_valid), 64'h0);
        chk("R1", "reset fault", 64'(rsp_fault), 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i]);
            req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
            chk_vec(VECS[i], vtag(i));
        end
        // R1: idle cycle after a request gives an empty response
        drive(VECS[0]);
        @(negedge clk);
        chk("R1", "idle valid", 64'(rsp_valid), 64'h0);
        chk("R1", "idle fault", 64'(rsp_fault), 64'h0);
        // R1: back-to-back requests each answered on the next cycle
        drive(VECS[11]);
        req_valid = 1'b1;
        @(negedge clk);
        chk_vec(VECS[11], "R1");
        drive(VECS[9]);
        @(negedge clk);
        req_valid = 1'b0;
        chk_vec(VECS[9], "R1");
        @(negedge clk);
        chk("R1", "tail valid", 64'(rsp_valid), 64'h0);
        // R1: reset in the middle clears a pending response
        drive(VECS[2]);
        req_valid = 1'b1;
        @(negedge clk);
        rst_n = 1'b0;
        req_valid = 1'b0;
        #1;
        chk("R1", "reset clears valid", 64'(rsp_valid), 64'h0);
        chk("R1", "reset clears paddr", 64'(rsp_paddr), 64'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule